// File: doc/BRIEF.md
# Multi-Slot Symbol Timing and Frequency Correction Controller

This block steers the symbol timing loop and the frequency correction of a burst receiver that serves four time slots. A phase detector upstream supplies one signed timing-error sample per symbol. The block adds a gain-scaled copy of that sample, plus the stored frequency correction, to a 10-bit symbol phase (1024 counts per symbol). It keeps a separate phase and frequency estimate for every slot, so each burst resumes from its own slot's state. A two-bit slot select picks the live context. When the select changes, the outgoing context is stored and the incoming one is loaded in the same clock.

Three control inputs drive the slot. The acquire input (preamble window) sets the loop gain and the averaging length. The AFC enable lets the frequency estimate be cleared and updated. The tracking enable gates every phase change. The gain controller is a three-state machine. In `G_SLOW` the step is 1x. `G_SLOW -> G_FAST` is taken when acquire is high. In `G_FAST` the step is 4x. `G_FAST -> G_HELD` is taken on a sample whose magnitude is below 1/8 symbol. In `G_HELD` the step is 1x while acquire stays high. `G_FAST -> G_SLOW` and `G_HELD -> G_SLOW` are both taken when acquire falls.

The frequency controller is a two-state machine. In `A_TRACK` it averages samples. `A_TRACK -> A_SETTLE` is taken on a clear. In `A_SETTLE` it waits a fixed delay. `A_SETTLE -> A_TRACK` is taken when that delay has run out. A separate combinational selector passes one of two receive channels' data, clock and symbol clock to a shared output.

Top module: `symbol_timing_ctrl`

## Requirements
- R1: After reset `dpll_phase`, `afc_freq`, `fast_mode` and `active_slot` are 0. All four slot contexts hold phase 0 and frequency 0.
- R2: A sample with `err_valid`=1 and `rec_en`=1 in a cycle without a slot switch takes effect at the next edge. The phase becomes (phase + afc_freq + k*phase_err) mod 1024, where `afc_freq` is the value held at the start of the cycle. k is 4 when `fast_mode` is 1 and 1 otherwise.
- R3: When `rec_en`=0 or `err_valid`=0, the phase is unchanged at the next edge unless a slot switch occurs.
- R4: In `G_SLOW`, `preamble`=1 makes `fast_mode` 1 from the next cycle. In `G_FAST`, a valid sample with |phase_err| < 128 makes `fast_mode` 0 from the next cycle. The loop then stays slow (`G_HELD`) while `preamble` remains 1.
- R5: `preamble`=0 returns the gain state to `G_SLOW`, so `fast_mode` is 0 in the next cycle.
- R6: The first cycle in which `afc_en` and `preamble` are both 1 (after a cycle where they were not both 1) is a clear. A clear sets `afc_freq` to 0 at the next edge and empties the averaging window. No sample is accumulated for the following 8 cycles.
- R7: In `A_TRACK`, each valid sample with `afc_en`=1 joins the window. The window closes on the sample that brings its count to 4 (`preamble`=1) or 16 (`preamble`=0). On that edge `afc_freq` increases by (window sum including that sample) arithmetically shifted right by 2 or 4, wrapping in 12-bit two's complement, and the window empties.
- R8: With `afc_en`=0 and no slot switch, `afc_freq` and the window contents are unchanged.
- R9: When `slot_sel` differs from `active_slot`, one edge does all of the following. It stores the live phase and frequency into the old slot and loads the new slot's phase and frequency. It sets `active_slot` to `slot_sel` and empties the window. It makes no phase step.
- R10: If a slot switch and an AFC clear fall in the same cycle, the frequency loaded for the new slot is 0. The old slot still receives its pre-switch frequency.
- R11: `rx_out` equals `ch2_rx` when `chan_sel`=1 and `ch1_rx` when `chan_sel`=0, combinationally. The bit order is [0] data, [1] bit clock, [2] symbol clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_sel | input | 2 | Requested slot context |
| preamble | input | 1 | Acquisition window: fast gain, short averaging |
| afc_en | input | 1 | Frequency estimation enable; with `preamble` triggers a clear |
| rec_en | input | 1 | Phase correction enable |
| err_valid | input | 1 | Qualifies `phase_err` |
| phase_err | input | 10 | Signed timing-error sample, 1024 counts per symbol |
| chan_sel | input | 1 | Receive channel routed to `rx_out` |
| ch1_rx | input | 3 | Channel 1 {symbol clock, bit clock, data} |
| ch2_rx | input | 3 | Channel 2 {symbol clock, bit clock, data} |
| rx_out | output | 3 | Selected channel outputs |
| dpll_phase | output | 10 | Live symbol phase |
| afc_freq | output | 12 | Live signed frequency correction |
| fast_mode | output | 1 | High loop gain active |
| active_slot | output | 2 | Slot whose context is live |

## Verification
A slot switch and an AFC clear can land on the same edge, and both write the live frequency register. The bench provokes this by raising `preamble` with `afc_en` already high in the same cycle that `slot_sel` changes. It then judges three things: the new slot comes up with a zero frequency, the old slot keeps its pre-switch estimate (read back by switching to it again later), and no phase step is taken. The random phase also lets window closes collide with switches and with the clear, and it compares every output against a cycle model each clock.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [1:0] {
        G_SLOW = 2'd0,
        G_FAST = 2'd1,
        G_HELD = 2'd2
    } gain_st_t;

    typedef enum logic {
        A_TRACK  = 1'b0,
        A_SETTLE = 1'b1
    } afc_st_t;

endpackage

// File: rtl/stc_gain_fsm.sv
module stc_gain_fsm
    import stc_pkg::*;
#(
    parameter int ERR_W    = 10,
    parameter int LOCK_THR = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    preamble,
    input  logic                    err_valid,
    input  logic signed [ERR_W-1:0] phase_err,
    output logic                    fast
);

    localparam logic [ERR_W:0] THR = (ERR_W+1)'(LOCK_THR);

    gain_st_t        st, st_n;
    logic [ERR_W:0]  mag;
    logic            near_lock;

    always_comb begin
        mag       = phase_err[ERR_W-1] ? -{phase_err[ERR_W-1], phase_err}
                                       : {1'b0, phase_err};
        near_lock = err_valid && (mag < THR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= G_SLOW;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            G_SLOW: if (preamble)       st_n = G_FAST;
            G_FAST: if (!preamble)      st_n = G_SLOW;
                    else if (near_lock) st_n = G_HELD;
            G_HELD: if (!preamble)      st_n = G_SLOW;
            default:                    st_n = G_SLOW;
        endcase
    end

    always_comb fast = (st == G_FAST);

    p_slow_without_preamble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !preamble |=> !fast);

    p_lock_leaves_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && preamble && near_lock) |=> !fast);

endmodule

// File: rtl/stc_afc_ctrl.sv
module stc_afc_ctrl
    import stc_pkg::*;
#(
    parameter int ERR_W     = 10,
    parameter int FREQ_W    = 12,
    parameter int FAST_LG   = 2,
    parameter int SLOW_LG   = 4,
    parameter int AFC_DELAY = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     afc_en,
    input  logic                     preamble,
    input  logic                     err_valid,
    input  logic signed [ERR_W-1:0]  phase_err,
    input  logic                     slot_switch,
    output logic                     clr,
    output logic                     upd,
    output logic signed [FREQ_W-1:0] avg
);

    localparam int SUM_W = ERR_W + SLOW_LG + 1;
    localparam int CNT_W = SLOW_LG + 1;
    localparam int DLY_W = $clog2(AFC_DELAY + 1);
    localparam logic [CNT_W-1:0] FAST_N = CNT_W'(1 << FAST_LG);
    localparam logic [CNT_W-1:0] SLOW_N = CNT_W'(1 << SLOW_LG);
    localparam logic [DLY_W-1:0] DLY    = DLY_W'(AFC_DELAY);

    afc_st_t                  st, st_n;
    logic [DLY_W-1:0]         wcnt, wcnt_n;
    logic                     trig_q;
    logic signed [SUM_W-1:0]  sum, sum_n, sum_nx, shifted;
    logic [CNT_W-1:0]         cnt, cnt_n, cnt_inc;
    logic                     trig, take, full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= A_TRACK;
            wcnt   <= '0;
            trig_q <= 1'b0;
            sum    <= '0;
            cnt    <= '0;
        end else begin
            st     <= st_n;
            wcnt   <= wcnt_n;
            trig_q <= trig;
            sum    <= sum_n;
            cnt    <= cnt_n;
        end
    end

    always_comb begin
        trig    = afc_en && preamble;
        clr     = trig && !trig_q;
        sum_nx  = sum + SUM_W'(phase_err);
        cnt_inc = cnt + 1'b1;
        take    = (st == A_TRACK) && afc_en && err_valid && !clr && !slot_switch;
        full    = preamble ? (cnt_inc >= FAST_N) : (cnt_inc >= SLOW_N);
        upd     = take && full;
        shifted = preamble ? (sum_nx >>> FAST_LG) : (sum_nx >>> SLOW_LG);
        avg     = FREQ_W'(shifted);

        st_n   = st;
        wcnt_n = wcnt;
        unique case (st)
            A_TRACK: begin
                if (clr) begin
                    st_n   = A_SETTLE;
                    wcnt_n = DLY;
                end
            end
            A_SETTLE: begin
                if (clr) begin
                    wcnt_n = DLY;
                end else begin
                    if (wcnt == DLY_W'(1)) st_n = A_TRACK;
                    wcnt_n = wcnt - 1'b1;
                end
            end
            default: st_n = A_TRACK;
        endcase

        if (clr || slot_switch || upd) begin
            sum_n = '0;
            cnt_n = '0;
        end else if (take) begin
            sum_n = sum_nx;
            cnt_n = cnt_inc;
        end else begin
            sum_n = sum;
            cnt_n = cnt;
        end
    end

    p_clear_enters_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st == A_SETTLE) && (cnt == '0));

    p_window_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < SLOW_N);

endmodule

// File: rtl/stc_slot_bank.sv
module stc_slot_bank #(
    parameter int PHASE_W = 10,
    parameter int FREQ_W  = 12,
    parameter int ERR_W   = 10,
    parameter int SLOTS   = 4,
    parameter int SEL_W   = $clog2(SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         slot_sel,
    input  logic                     err_valid,
    input  logic                     rec_en,
    input  logic signed [ERR_W-1:0]  phase_err,
    input  logic                     fast,
    input  logic                     afc_clr,
    input  logic                     afc_upd,
    input  logic signed [FREQ_W-1:0] afc_avg,
    output logic                     slot_switch,
    output logic [PHASE_W-1:0]       dpll_phase,
    output logic signed [FREQ_W-1:0] afc_freq,
    output logic [SEL_W-1:0]         active_slot
);

    logic [PHASE_W-1:0]        ph, ph_n, err_ext, step;
    logic signed [FREQ_W-1:0]  fr, fr_n;
    logic [SEL_W-1:0]          act;
    logic                      apply;
    logic [PHASE_W-1:0]        ctx_ph [SLOTS];
    logic signed [FREQ_W-1:0]  ctx_fr [SLOTS];

    always_comb begin
        slot_switch = (slot_sel != act);
        apply       = err_valid && rec_en && !slot_switch;
        err_ext     = PHASE_W'(phase_err);
        step        = fast ? (err_ext << 2) : err_ext;
        if (slot_switch) begin
            ph_n = ctx_ph[slot_sel];
            fr_n = afc_clr ? '0 : ctx_fr[slot_sel];
        end else begin
            ph_n = apply ? (ph + PHASE_W'(fr) + step) : ph;
            if (afc_clr)      fr_n = '0;
            else if (afc_upd) fr_n = fr + afc_avg;
            else              fr_n = fr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= '0;
            fr  <= '0;
            act <= '0;
        end else begin
            ph  <= ph_n;
            fr  <= fr_n;
            act <= slot_sel;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_ctx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctx_ph[g] <= '0;
                ctx_fr[g] <= '0;
            end else if (slot_switch && (act == SEL_W'(g))) begin
                ctx_ph[g] <= ph;
                ctx_fr[g] <= fr;
            end
        end
    end

    always_comb begin
        dpll_phase  = ph;
        afc_freq    = fr;
        active_slot = act;
    end

    p_switch_adopts_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_switch |=> (active_slot == $past(slot_sel)));

    p_switch_saves_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_switch |=> (ctx_ph[$past(act)] == $past(ph)));

endmodule

// File: rtl/stc_rx_route.sv
module stc_rx_route #(
    parameter int LANES = 3
) (
    input  logic             chan_sel,
    input  logic [LANES-1:0] ch1_rx,
    input  logic [LANES-1:0] ch2_rx,
    output logic [LANES-1:0] rx_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb rx_out[g] = chan_sel ? ch2_rx[g] : ch1_rx[g];
    end

endmodule

// File: rtl/symbol_timing_ctrl.sv
module symbol_timing_ctrl #(
    parameter int PHASE_W   = 10,
    parameter int ERR_W     = 10,
    parameter int FREQ_W    = 12,
    parameter int SLOTS     = 4,
    parameter int LOCK_DIV  = 8,
    parameter int FAST_LG   = 2,
    parameter int SLOW_LG   = 4,
    parameter int AFC_DELAY = 8,
    parameter int LANES     = 3,
    localparam int SEL_W    = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   slot_sel,
    input  logic               preamble,
    input  logic               afc_en,
    input  logic               rec_en,
    input  logic               err_valid,
    input  logic [ERR_W-1:0]   phase_err,
    input  logic               chan_sel,
    input  logic [LANES-1:0]   ch1_rx,
    input  logic [LANES-1:0]   ch2_rx,
    output logic [LANES-1:0]   rx_out,
    output logic [PHASE_W-1:0] dpll_phase,
    output logic [FREQ_W-1:0]  afc_freq,
    output logic               fast_mode,
    output logic [SEL_W-1:0]   active_slot
);

    localparam int LOCK_THR = (1 << PHASE_W) / LOCK_DIV;

    logic signed [ERR_W-1:0]  err_s;
    logic                     slot_switch, afc_clr, afc_upd;
    logic signed [FREQ_W-1:0] afc_avg, fr_s;

    always_comb err_s = $signed(phase_err);

    stc_gain_fsm #(.ERR_W(ERR_W), .LOCK_THR(LOCK_THR)) u_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .preamble  (preamble),
        .err_valid (err_valid),
        .phase_err (err_s),
        .fast      (fast_mode)
    );

    stc_afc_ctrl #(
        .ERR_W(ERR_W), .FREQ_W(FREQ_W), .FAST_LG(FAST_LG),
        .SLOW_LG(SLOW_LG), .AFC_DELAY(AFC_DELAY)
    ) u_afc (
        .clk         (clk),
        .rst_n       (rst_n),
        .afc_en      (afc_en),
        .preamble    (preamble),
        .err_valid   (err_valid),
        .phase_err   (err_s),
        .slot_switch (slot_switch),
        .clr         (afc_clr),
        .upd         (afc_upd),
        .avg         (afc_avg)
    );

    stc_slot_bank #(
        .PHASE_W(PHASE_W), .FREQ_W(FREQ_W), .ERR_W(ERR_W), .SLOTS(SLOTS)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_sel    (slot_sel),
        .err_valid   (err_valid),
        .rec_en      (rec_en),
        .phase_err   (err_s),
        .fast        (fast_mode),
        .afc_clr     (afc_clr),
        .afc_upd     (afc_upd),
        .afc_avg     (afc_avg),
        .slot_switch (slot_switch),
        .dpll_phase  (dpll_phase),
        .afc_freq    (fr_s),
        .active_slot (active_slot)
    );

    always_comb afc_freq = fr_s;

    stc_rx_route #(.LANES(LANES)) u_route (
        .chan_sel (chan_sel),
        .ch1_rx   (ch1_rx),
        .ch2_rx   (ch2_rx),
        .rx_out   (rx_out)
    );

    p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_en && !slot_switch) |=> $stable(dpll_phase));

    p_freq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!afc_en && !slot_switch) |=> $stable(afc_freq));

    p_clear_zeroes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        afc_clr |=> (afc_freq == '0));

endmodule

// File: tb/symbol_timing_ctrl_test.sv
`timescale 1ns/1ps
module symbol_timing_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] slot_sel;
    logic       preamble, afc_en, rec_en, err_valid, chan_sel;
    logic [9:0] phase_err;
    logic [2:0] ch1_rx, ch2_rx, rx_out;
    logic [9:0] dpll_phase;
    logic [11:0] afc_freq;
    logic       fast_mode;
    logic [1:0] active_slot;

    always #2.5 clk = ~clk;

    symbol_timing_ctrl uut (
        .clk(clk), .rst_n(rst_n), .slot_sel(slot_sel), .preamble(preamble),
        .afc_en(afc_en), .rec_en(rec_en), .err_valid(err_valid),
        .phase_err(phase_err), .chan_sel(chan_sel), .ch1_rx(ch1_rx),
        .ch2_rx(ch2_rx), .rx_out(rx_out), .dpll_phase(dpll_phase),
        .afc_freq(afc_freq), .fast_mode(fast_mode), .active_slot(active_slot)
    );

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    int m_ph, m_fr, m_slot, m_gst, m_ast, m_wcnt, m_sum, m_cnt;
    bit m_trigq;
    int m_cph [4];
    int m_cfr [4];

    function automatic int wrap_fr(int x);
        int y;
        y = x & 4095;
        if (y >= 2048) y = y - 4096;
        return y;
    endfunction

    task automatic chk(string tag, int act, int exp, string what);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick(input logic [1:0] sl, input bit pr, input bit af,
                        input bit re, input bit va, input logic [9:0] e);
        string tp, tf, tg;
        int err, nn, lg, avg, nph, nfr;
        bit sw, trig, clr, fast, apply, take, done;
        slot_sel = sl; preamble = pr; afc_en = af; rec_en = re;
        err_valid = va; phase_err = e;
        chan_sel = 1'($urandom); ch1_rx = 3'($urandom); ch2_rx = 3'($urandom);
        #1;
        chk("R11", int'(rx_out), int'(chan_sel ? ch2_rx : ch1_rx), "rx_out");

        err   = int'($signed(e));
        sw    = (int'(sl) != m_slot);
        trig  = af && pr;
        clr   = trig && !m_trigq;
        fast  = (m_gst == 1);
        apply = va && re && !sw;
        nn    = pr ? 4 : 16;
        lg    = pr ? 2 : 4;
        take  = (m_ast == 0) && af && va && !clr && !sw;
        done  = take && (m_cnt + 1 >= nn);
        avg   = (m_sum + err) >>> lg;

        if (sw) begin
            m_cph[m_slot] = m_ph;
            m_cfr[m_slot] = m_fr;
            nph = m_cph[int'(sl)];
            nfr = clr ? 0 : m_cfr[int'(sl)];
            tp = "R9";
            tf = clr ? "R10" : "R9";
        end else begin
            nph = apply ? ((m_ph + m_fr + (fast ? err * 4 : err)) & 1023) : m_ph;
            nfr = clr ? 0 : (done ? wrap_fr(m_fr + avg) : m_fr);
            tp = apply ? "R2" : "R3";
            tf = clr ? "R6" : (done ? "R7" : (!af ? "R8" : "R7"));
        end

        if (clr || sw || done) begin
            m_sum = 0; m_cnt = 0;
        end else if (take) begin
            m_sum = m_sum + err; m_cnt = m_cnt + 1;
        end
        if (clr) begin
            m_ast = 1; m_wcnt = 8;
        end else if (m_ast == 1) begin
            if (m_wcnt == 1) m_ast = 0;
            m_wcnt = m_wcnt - 1;
        end
        m_trigq = trig;

        tg = pr ? "R4" : "R5";
        case (m_gst)
            0: if (pr) m_gst = 1;
            1: if (!pr) m_gst = 0;
               else if (va && (err < 128) && (err > -128)) m_gst = 2;
            default: if (!pr) m_gst = 0;
        endcase

        m_ph = nph; m_fr = nfr; m_slot = int'(sl);

        @(posedge clk);
        @(negedge clk);
        chk(tp, int'(dpll_phase), m_ph, "dpll_phase");
        chk(tf, int'($signed(afc_freq)), m_fr, "afc_freq");
        chk(tg, int'(fast_mode), int'(m_gst == 1), "fast_mode");
        chk("R9", int'(active_slot), m_slot, "active_slot");
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] sl;
        bit pr;
        void'($urandom(32'd24681));
        m_ph = 0; m_fr = 0; m_slot = 0; m_gst = 0; m_ast = 0; m_wcnt = 0;
        m_sum = 0; m_cnt = 0; m_trigq = 0;
        for (int k = 0; k < 4; k++) begin m_cph[k] = 0; m_cfr[k] = 0; end
        rst_n = 1'b0; slot_sel = '0; preamble = 0; afc_en = 0; rec_en = 0;
        err_valid = 0; phase_err = '0; chan_sel = 0; ch1_rx = '0; ch2_rx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", int'(dpll_phase), 0, "dpll_phase");
        chk("R1", int'(afc_freq), 0, "afc_freq");
        chk("R1", int'(fast_mode), 0, "fast_mode");
        chk("R1", int'(active_slot), 0, "active_slot");
        @(negedge clk);

        // R2 slow steps, R3 hold with rec_en low
        tick(2'd0, 0, 0, 1, 1, 10'd37);
        tick(2'd0, 0, 0, 1, 1, 10'h3F0);
        for (int i = 0; i < 4; i++) tick(2'd0, 0, 0, 0, 1, 10'd200);
        tick(2'd0, 0, 0, 1, 0, 10'd200);

        // R4 acquire: large errors keep fast, small error hands over, R5 release
        tick(2'd0, 1, 0, 1, 1, 10'd300);
        tick(2'd0, 1, 0, 1, 1, 10'd300);
        tick(2'd0, 1, 0, 1, 1, 10'h2D0);
        tick(2'd0, 1, 0, 1, 1, 10'd127);
        tick(2'd0, 1, 0, 1, 1, 10'd5);
        tick(2'd0, 0, 0, 1, 1, 10'd5);

        // R6 clear then settle, R7 short windows, R8 hold
        tick(2'd0, 0, 1, 1, 1, 10'd40);
        tick(2'd0, 1, 1, 1, 1, 10'd40);
        for (int i = 0; i < 16; i++) tick(2'd0, 1, 1, 1, 1, 10'd100 + 10'(i));
        for (int i = 0; i < 20; i++) tick(2'd0, 0, 1, 1, 1, 10'h3C0);
        for (int i = 0; i < 6; i++) tick(2'd0, 0, 0, 1, 1, 10'd90);

        // R9 switch away and back, R10 switch with clear
        tick(2'd1, 0, 1, 1, 1, 10'd50);
        tick(2'd1, 0, 1, 1, 1, 10'd50);
        tick(2'd3, 1, 1, 1, 1, 10'd50);
        tick(2'd3, 1, 1, 1, 1, 10'd60);
        tick(2'd0, 0, 1, 1, 1, 10'd60);
        tick(2'd1, 0, 1, 1, 1, 10'd60);

        // random traffic
        sl = 2'd1; pr = 0;
        for (int i = 0; i < 4000; i++) begin
            logic [9:0] e;
            if ($urandom % 16 == 0) sl = 2'($urandom);
            if ($urandom % 24 == 0) pr = !pr;
            if ($urandom % 3 == 0) e = 10'(int'($urandom % 201) - 100);
            else                   e = 10'($urandom);
            tick(sl, pr, ($urandom % 8) != 0, ($urandom % 8) != 0,
                 ($urandom % 4) != 0, e);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule